// File: doc/BRIEF.md
# Truth-Table Carry-Chain ALU

A purely combinational arithmetic and logic unit of parameter width (eight bits by default). Two small programmable units sit in front of a ripple carry chain. Each one looks at the bit pair of A and B and reads its output from a four-bit control word that acts as a truth table. One unit supplies the generate term of every bit and the other supplies the propagate term. The same chain then adds, subtracts, decrements, passes logic results through, or shifts left, depending only on the two control words and the carry input.

A right-shift select steers a 2:1 multiplexer inside the propagate path, ahead of the sum logic. While it is set, the generate terms and the incoming carry are held at zero, so the shift can never turn into an increment. A flag reports when every result bit is zero. The block has no registers. Operation decoding belongs to the surrounding datapath.

Top module: `gp_alu`

## Requirements
- R1: Each unit's output for a bit is control bit number 2*B+A of its control word. With generate word 0000, carry input 0 and no right shift, Q equals the propagate function of A and B bitwise, and carry_out is 0.
- R2: Generate 1000 with propagate 1110 gives {carry_out,Q} = A + B + cin.
- R3: Generate 0010 with propagate 1011 gives {carry_out,Q} = A + ~B + cin, which is A − B − (1 − cin), with carry_out meaning no borrow.
- R4: Generate 0100 with propagate 1101 gives {carry_out,Q} = B + ~A + cin.
- R5: Propagate 1111 with generate 1010 gives A + all-ones + cin. Propagate 1111 with generate 1100 gives B + all-ones + cin.
- R6: When the generate word equals the propagate word, or the propagate word is 0000, and right shift is off, Q = (f << 1) | cin and carry_out = the top bit of f, where f is the generate function.
- R7: With right shift on, Q = {sin, f[W-1:1]} and carry_out = f[0], where f is the propagate function. The generate word and cin have no effect.
- R8: zero is 1 exactly when all Q bits are 0.
- R9: With right shift off, for any control words, {carry_out,Q} = cin + the sum over bits of weight(i)·2^i. Weight(i) is 2 when generate is 1, 1 when only propagate is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | Operand A |
| b | input | W | Operand B |
| gen_ctl | input | 4 | Truth table of the generate unit |
| prop_ctl | input | 4 | Truth table of the propagate unit |
| cin | input | 1 | Carry into bit 0; shift-in bit for left shift |
| rsh | input | 1 | Right-shift select |
| sin | input | 1 | Bit shifted into the top during right shift |
| q | output | W | Result |
| cout | output | 1 | Carry out of the top bit, or bit shifted out on right shift |
| zero | output | 1 | All result bits are zero |

## Verification
The hardest case is a carry that ripples through every bit: all propagate terms set, no generate term set, and a carry arriving at bit 0. With uniform random operands this combination almost never appears for the arithmetic words. Directed vectors therefore apply operand pairs whose sum is exactly all-ones or wraps to zero, with cin set to 1, under the add, subtract and decrement words. These same vectors also drive the zero flag to 1 from a nonzero carry. Random control words and operands then cover the general weighting rule and the right-shift path.

// File: rtl/gp_alu.sv
module gp_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   gen_ctl,
  input  logic [3:0]   prop_ctl,
  input  logic         cin,
  input  logic         rsh,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         cout,
  output logic         zero
);
  logic [W-1:0] g_lu, p_lu, g, p;
  logic [W:0]   c;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign g_lu[i]  = gen_ctl[{b[i], a[i]}];
      assign p_lu[i]  = prop_ctl[{b[i], a[i]}];
      assign c[i+1]   = g[i] | (p[i] & c[i]);
      assign q[i]     = (p[i] & ~g[i]) ^ c[i];
    end
  endgenerate

  assign p    = rsh ? {sin, p_lu[W-1:1]} : p_lu;
  assign g    = rsh ? '0 : g_lu;
  assign c[0] = cin & ~rsh;
  assign cout = rsh ? p_lu[0] : c[W];
  assign zero = ~|q;
endmodule

// File: rtl/gp_alu_props.sv
module gp_alu_props #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   gen_ctl,
  input logic [3:0]   prop_ctl,
  input logic         cin,
  input logic         rsh,
  input logic         sin,
  input logic [W-1:0] q,
  input logic         cout,
  input logic         zero
);
  function automatic logic [W-1:0] tt(input logic [3:0] t, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = t[{y[k], x[k]}];
    return r;
  endfunction

  logic [W-1:0] pf;
  logic [W:0]   sum_ab, sum_amb, sum_bma;
  always_comb begin
    pf      = tt(prop_ctl, a, b);
    sum_ab  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum_amb = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
    sum_bma = {1'b0, b} + {1'b0, ~a} + {{W{1'b0}}, cin};
    if (!rsh && gen_ctl == 4'b0000 && !cin)
      p_logic_r1: assert (q == pf && !cout) else $error("R1 logic result mismatch");
    if (!rsh && gen_ctl == 4'b1000 && prop_ctl == 4'b1110)
      p_add_r2: assert ({cout, q} == sum_ab) else $error("R2 add mismatch");
    if (!rsh && gen_ctl == 4'b0010 && prop_ctl == 4'b1011)
      p_sub_r3: assert ({cout, q} == sum_amb) else $error("R3 A-B mismatch");
    if (!rsh && gen_ctl == 4'b0100 && prop_ctl == 4'b1101)
      p_rsub_r4: assert ({cout, q} == sum_bma) else $error("R4 B-A mismatch");
    if (rsh)
      p_rshift_r7: assert (q == {sin, pf[W-1:1]} && cout == pf[0]) else $error("R7 right shift mismatch");
    if (zero)
      p_zero_r8: assert (q == '0) else $error("R8 zero with nonzero result");
  end
endmodule

bind gp_alu gp_alu_props #(.W(W)) u_props (.*);

// File: tb/gp_alu_test.sv
module gp_alu_test;
  localparam int W = 8;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, q;
  logic [3:0] gen_ctl, prop_ctl;
  logic cin, rsh, sin, cout, zero;
  int checks = 0, errors = 0;
  bit done = 0;

  gp_alu #(.W(W)) uut (.*);

  function automatic logic [W-1:0] tt(input logic [3:0] t, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = t[{y[k], x[k]}];
    return r;
  endfunction

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
      input logic [3:0] gc, input logic [3:0] pc, input logic ci, input logic rs, input logic si);
    logic [W+1:0] acc;
    logic [W-1:0] gf, pf;
    gf = tt(gc, x, y);
    pf = tt(pc, x, y);
    if (rs) return {pf[0], si, pf[W-1:1]};
    acc = {{(W+1){1'b0}}, ci};
    for (int k = 0; k < W; k++)
      if (gf[k]) acc = acc + ((W+2)'(2) << k);
      else if (pf[k]) acc = acc + ((W+2)'(1) << k);
    return acc[W:0];
  endfunction

  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
      input logic [3:0] gc, input logic [3:0] pc, input logic ci, input logic rs, input logic si,
      input logic [W:0] exp);
    @(posedge clk);
    a = x; b = y; gen_ctl = gc; prop_ctl = pc; cin = ci; rsh = rs; sin = si;
    @(negedge clk);
    checks++;
    if ({cout, q} !== exp || zero !== (exp[W-1:0] == '0)) begin
      errors++;
      $display("FAIL %s: got cout=%b q=%h zero=%b expected cout=%b q=%h zero=%b",
               req, cout, q, zero, exp[W], exp[W-1:0], exp[W-1:0] == '0);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y, f;
    logic [3:0] gc, pc;
    logic ci, rs, si;
    void'($urandom(32'd2718));
    a = 0; b = 0; gen_ctl = 0; prop_ctl = 0; cin = 0; rsh = 0; sin = 0;
    apply("R8 idle", 0, 0, 4'b0000, 4'b0000, 0, 0, 0, '0);
    // R1 logic functions via truth tables
    apply("R1 and", 8'hCA, 8'h5F, 4'b0000, 4'b1000, 0, 0, 0, {1'b0, 8'hCA & 8'h5F});
    apply("R1 or",  8'hCA, 8'h50, 4'b0000, 4'b1110, 0, 0, 0, {1'b0, 8'hCA | 8'h50});
    apply("R1 xor", 8'hCA, 8'h5F, 4'b0000, 4'b0110, 0, 0, 0, {1'b0, 8'hCA ^ 8'h5F});
    apply("R1 notb", 8'h00, 8'h3C, 4'b0000, 4'b0011, 0, 0, 0, {1'b0, ~8'h3C});
    // R2 add, including full ripple
    apply("R2 add", 8'h37, 8'h4A, 4'b1000, 4'b1110, 0, 0, 0, 9'h081);
    apply("R2 ripple", 8'hF0, 8'h0F, 4'b1000, 4'b1110, 1, 0, 0, 9'h100);
    apply("R2 allones", 8'hF0, 8'h0F, 4'b1000, 4'b1110, 0, 0, 0, 9'h0FF);
    // R3 / R4 subtraction
    apply("R3 sub", 8'h50, 8'h20, 4'b0010, 4'b1011, 1, 0, 0, 9'h130);
    apply("R3 borrow", 8'h20, 8'h50, 4'b0010, 4'b1011, 1, 0, 0, 9'h0D0);
    apply("R3 equal", 8'h77, 8'h77, 4'b0010, 4'b1011, 1, 0, 0, 9'h100);
    apply("R4 rsub", 8'h20, 8'h50, 4'b0100, 4'b1101, 1, 0, 0, 9'h130);
    apply("R4 nocarry", 8'h20, 8'h50, 4'b0100, 4'b1101, 0, 0, 0, 9'h12F);
    // R5 pass/decrement
    apply("R5 passA", 8'h42, 8'h99, 4'b1010, 4'b1111, 1, 0, 0, 9'h142);
    apply("R5 decA", 8'h00, 8'h99, 4'b1010, 4'b1111, 0, 0, 0, 9'h0FF);
    apply("R5 passB", 8'h42, 8'h99, 4'b1100, 4'b1111, 1, 0, 0, 9'h199);
    apply("R5 decB", 8'h42, 8'h01, 4'b1100, 4'b1111, 0, 0, 0, 9'h100);
    // R6 left shift
    apply("R6 shlA", 8'hA5, 8'h00, 4'b1010, 4'b1010, 1, 0, 0, 9'h14B);
    apply("R6 shlA p0", 8'h5A, 8'h00, 4'b1010, 4'b0000, 0, 0, 0, 9'h0B4);
    apply("R6 shl zero", 8'h80, 8'h00, 4'b1010, 4'b0000, 0, 0, 0, 9'h100);
    // R7 right shift, gen and cin ignored
    apply("R7 shrA", 8'hA5, 8'h00, 4'b1111, 4'b1010, 1, 1, 0, 9'h152);
    apply("R7 shr sin", 8'h02, 8'h00, 4'b0000, 4'b1010, 0, 1, 1, 9'h081);
    apply("R7 shr zero", 8'h01, 8'h00, 4'b1000, 4'b1010, 1, 1, 0, 9'h100);
    // R9 random combinations
    for (int n = 0; n < 3000; n++) begin
      x = W'($urandom); y = W'($urandom);
      gc = 4'($urandom); pc = 4'($urandom);
      ci = 1'($urandom); rs = ($urandom % 4) == 0; si = 1'($urandom);
      apply(rs ? "R7 random" : "R9 random", x, y, gc, pc, ci, rs, si, model(x, y, gc, pc, ci, rs, si));
    end
    // R6 random left shift with equal words
    for (int n = 0; n < 200; n++) begin
      x = W'($urandom); y = W'($urandom); gc = 4'($urandom); ci = 1'($urandom);
      f = tt(gc, x, y);
      apply("R6 random", x, y, gc, gc, ci, 0, 0, {f[W-1], f[W-2:0], ci});
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule